// File: doc/BRIEF.md
# Incremental ADC Decimation Combiner

This block is the digital back end of a second-order incremental delta-sigma converter. A conversion opens with a start pulse. The modulator then supplies one bit per clock for M cycles, where M is the oversampling ratio. Each bit either adds or subtracts the tap weight for its position. All the weighted bits are summed in a single accumulator, which is cleared at the start of every conversion.

After the last bit, the signed code from an auxiliary residue ADC is multiplied by a programmable path gain and added to the sum. The block then presents the result as one decimated word with a one-cycle strobe. The tap weights can be arbitrary, so they can correct for leaky integrators. A ramp mode replaces them with the ideal cascade-of-integrator weights.

Tap weights and the path gain are loaded through a write port while the block is idle.

Top module: `decim_combiner`

## Requirements
- R1: The output word equals the sum over tap positions m of s[m]·h[m], plus g·r, with all terms signed. Here s[m] is +1 for a bit of 1 and −1 for a bit of 0, h[m] is the 18-bit signed weight stored at write address m, g is the 16-bit signed gain taken from the low bits of a write to address MAX_TAPS, and r is the residue code read as 8-bit two's complement.
- R2: The oversampling select sets the tap count M: code 0 gives 64, code 1 gives 128, and codes 2 and 3 give 256.
- R3: When the ramp mode input is high at the start pulse, tap 0 weighs 0 and tap m (m ≥ 1) weighs M − m. The stored weights are not used for that conversion.
- R4: The accumulator is cleared at each start, so a result depends only on its own conversion.
- R5: The residue code is sampled once, at the clock edge after the edge that takes the last bit. Its value at any other time has no effect.
- R6: Bit m is taken at the (m+1)-th rising edge after the start edge. The result and a one-cycle valid pulse appear at edge M+2. The output word then holds until the next result.
- R7: Busy is high from the edge after the start until the edge that raises valid. While busy is high, writes to the tap weights and the gain are ignored.
- R8: A start pulse while busy is dropped, and the running conversion finishes with unchanged timing and value.
- R9: After reset, busy and valid are low and the output word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a conversion when idle |
| osr_sel | input | 2 | Oversampling ratio select |
| ramp_mode | input | 1 | Use the built-in ramp weights for this conversion |
| bit_in | input | 1 | Modulator bitstream |
| res_code | input | 8 | Residue ADC code, signed |
| wr_en | input | 1 | Write strobe for weights and gain |
| wr_addr | input | 9 | Tap index, or MAX_TAPS for the gain |
| wr_data | input | 18 | Write data |
| busy | output | 1 | Conversion in progress |
| dout | output | 32 | Decimated result, signed |
| dout_valid | output | 1 | One-cycle result strobe |

## Verification
The assertions check the protocol on every cycle. Valid is a single-cycle pulse that coincides with busy falling. Busy rises only after a start pulse. The output word changes only when valid rises. The tap index steps by one per cycle until the last tap, whatever happens on start.

Only the bench scenarios can show that the arithmetic is right: the signed weighting of each bit, the ramp weights, the residue sampling instant, the tap count for each ratio select, and that writes made while busy are ignored. The bench shows these by comparing results against sums it computes itself.

// File: rtl/decim_combiner.sv
module decim_combiner #(
  parameter int MAX_TAPS = 256,
  parameter int W_COEF   = 18,
  parameter int W_GAIN   = 16,
  parameter int W_RES    = 8,
  parameter int W_ACC    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        osr_sel,
  input  logic              ramp_mode,
  input  logic              bit_in,
  input  logic [W_RES-1:0]  res_code,
  input  logic              wr_en,
  input  logic [$clog2(MAX_TAPS):0] wr_addr,
  input  logic [W_COEF-1:0] wr_data,
  output logic              busy,
  output logic [W_ACC-1:0]  dout,
  output logic              dout_valid
);
  localparam int IDXW = $clog2(MAX_TAPS);
  localparam int AW   = IDXW + 1;
  localparam int W_PR = W_GAIN + W_RES;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_RES, S_FIN} st_t;

  st_t                      st;
  logic [IDXW-1:0]          idx, last_idx;
  logic                     ramp_q;
  logic signed [W_ACC-1:0]  acc;
  logic signed [W_GAIN-1:0] gain;
  logic signed [W_COEF-1:0] coef [MAX_TAPS];

  logic [IDXW-1:0]          n_last;
  logic [AW-1:0]            ramp_w;
  logic signed [W_COEF-1:0] w_sel;
  logic signed [W_ACC-1:0]  w_ext, tap_term, res_term;
  logic signed [W_PR-1:0]   res_prod;
  logic                     in_run;

  always_comb begin
    case (osr_sel)
      2'd0:    n_last = IDXW'(MAX_TAPS/4 - 1);
      2'd1:    n_last = IDXW'(MAX_TAPS/2 - 1);
      default: n_last = IDXW'(MAX_TAPS - 1);
    endcase
  end

  assign busy     = (st != S_IDLE);
  assign in_run   = (st == S_RUN);
  assign ramp_w   = (idx == '0) ? '0 : ({1'b0, last_idx} + AW'(1) - {1'b0, idx});
  assign w_sel    = ramp_q ? W_COEF'(ramp_w) : coef[idx];
  assign w_ext    = W_ACC'(w_sel);
  assign tap_term = bit_in ? w_ext : -w_ext;
  assign res_prod = gain * $signed(res_code);
  assign res_term = W_ACC'(res_prod);

  always_ff @(posedge clk)
    if (wr_en && !busy && !wr_addr[IDXW])
      coef[wr_addr[IDXW-1:0]] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      last_idx   <= '0;
      ramp_q     <= 1'b0;
      acc        <= '0;
      gain       <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (wr_en && wr_addr == AW'(MAX_TAPS))
            gain <= wr_data[W_GAIN-1:0];
          if (start) begin
            st       <= S_RUN;
            acc      <= '0;
            idx      <= '0;
            last_idx <= n_last;
            ramp_q   <= ramp_mode;
          end
        end
        S_RUN: begin
          acc <= acc + tap_term;
          idx <= idx + IDXW'(1);
          if (idx == last_idx) st <= S_RES;
        end
        S_RES: begin
          acc <= acc + res_term;
          st  <= S_FIN;
        end
        default: begin
          dout       <= acc;
          dout_valid <= 1'b1;
          st         <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/decim_combiner_chk.sv
module decim_combiner_chk #(
  parameter int MAX_TAPS = 256,
  parameter int W_ACC    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start,
  input logic                        busy,
  input logic                        dout_valid,
  input logic [W_ACC-1:0]            dout,
  input logic                        in_run,
  input logic [$clog2(MAX_TAPS)-1:0] tap_idx,
  input logic [$clog2(MAX_TAPS)-1:0] last_idx
);
  localparam int IDXW = $clog2(MAX_TAPS);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> !dout_valid);

  assert_dout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> $stable(dout));

  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> !busy);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> dout_valid);

  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_idx_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && tap_idx != last_idx) |=> (in_run && tap_idx == $past(tap_idx) + IDXW'(1)));

  assert_run_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && tap_idx == last_idx) |=> !in_run);
endmodule

bind decim_combiner decim_combiner_chk #(.MAX_TAPS(MAX_TAPS), .W_ACC(W_ACC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .dout_valid(dout_valid),
  .dout(dout), .in_run(in_run), .tap_idx(idx), .last_idx(last_idx)
);

// File: tb/decim_combiner_tb.sv
module decim_combiner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  osr_sel = 2'd0;
  logic        ramp_mode = 1'b0;
  logic        bit_in = 1'b0;
  logic [7:0]  res_code = 8'd0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = 9'd0;
  logic [17:0] wr_data = 18'd0;
  logic        busy;
  logic [31:0] dout;
  logic        dout_valid;

  int n_chk = 0;
  int n_fail = 0;
  int coef [256];
  int kk = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  decim_combiner u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .osr_sel(osr_sel), .ramp_mode(ramp_mode),
    .bit_in(bit_in), .res_code(res_code), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .dout(dout), .dout_valid(dout_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 9'(addr); wr_data = 18'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic bit pat_bit(input int p, input int m);
    case (p)
      0: return 1'b1;
      1: return 1'b0;
      2: return 1'(m & 1);
      default: return ((m * m * 7 + m * 3 + p) % 5) < 2;
    endcase
  endfunction

  task automatic conv(input int sel, input bit ramp, input int p, input int res_a,
                      input int res_b, input bit poke, input string tag);
    int M;
    longint exp;
    logic [31:0] held;
    M = (sel == 0) ? 64 : (sel == 1) ? 128 : 256;
    exp = 0;
    @(negedge clk);
    start = 1'b1; osr_sel = 2'(sel); ramp_mode = ramp; res_code = 8'(res_a);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R7 busy after start ", tag}, longint'(busy), 1);
    for (int m = 0; m < M; m++) begin
      bit b;
      int w;
      b = pat_bit(p, m);
      bit_in = b;
      w = ramp ? ((m == 0) ? 0 : M - m) : coef[m];
      exp += b ? longint'(w) : -longint'(w);
      if (poke && m == 3) begin
        wr_en = 1'b1; wr_addr = 9'd5; wr_data = 18'd999;
      end else if (poke && m == 6) begin
        wr_en = 1'b1; wr_addr = 9'd256; wr_data = 18'd4321;
      end else begin
        wr_en = 1'b0;
      end
      start = (poke && m == 10);
      @(negedge clk);
    end
    wr_en = 1'b0; start = 1'b0;
    res_code = 8'(res_b);
    exp += longint'(kk) * longint'(res_b);
    @(negedge clk);
    chk(dout_valid == 1'b0 && busy == 1'b1, {"R6 no early valid ", tag}, longint'(dout_valid), 0);
    res_code = 8'(res_a);
    @(negedge clk);
    chk(dout_valid == 1'b1, {"R6 valid at M+2 ", tag}, longint'(dout_valid), 1);
    chk(busy == 1'b0, {"R7 busy low with valid ", tag}, longint'(busy), 0);
    chk(longint'($signed(dout)) == exp, {"R1 result ", tag}, longint'($signed(dout)), exp);
    held = dout;
    @(negedge clk);
    chk(dout_valid == 1'b0 && dout == held, {"R6 pulse and hold ", tag}, longint'(dout_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 busy reset", longint'(busy), 0);
    chk(dout_valid == 1'b0, "R9 valid reset", longint'(dout_valid), 0);
    chk(dout == 32'd0, "R9 dout reset", longint'(dout), 0);
    rst_n = 1'b1;
    for (int m = 0; m < 256; m++) begin
      coef[m] = ((m * 2731 + 517) % 262144) - 131072;
      wr(m, coef[m]);
    end
    kk = -1234;
    wr(256, kk);
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 2; r++)
        for (int p = 0; p < 4; p++)
          conv(s, r[0], p, 55, (p == 1) ? -128 : (p == 2) ? 127 : p * 9 - 20, 1'b0,
               $sformatf("R2 R3 sel%0d ramp%0d pat%0d", s, r, p));
    conv(0, 1'b0, 3, 100, -77, 1'b1, "R8 R7 poke");
    conv(0, 1'b0, 3, 100, -77, 1'b0, "R7 R4 after poke");
    conv(0, 1'b0, 0, 0, 0, 1'b0, "R4 zero residue");
    for (int m = 0; m < 256; m++) begin
      coef[m] = 131071;
      wr(m, coef[m]);
    end
    kk = 32767;
    wr(256, kk);
    conv(2, 1'b0, 0, -128, 127, 1'b0, "R1 R5 max positive");
    kk = -32768;
    wr(256, kk);
    conv(2, 1'b0, 1, 127, -128, 1'b0, "R1 R5 max negative");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule